// File: doc/BRIEF.md
# Configurable-Mode SPI Shift Engine

This block is the serial core of an SPI master. One transfer moves a single word of 1 to 32 bits. The word goes out most significant bit first, and the reply comes in over the same serial clock cycles. Each transfer selects its own clock polarity and clock phase, so all four SPI modes are available. Two independent suppress flags allow transmit-only or receive-only operation.

The serial clock is paced by a half-period count given in system clock cycles. A requester presents a word, a length, a mode and a delay, then raises `start` for one cycle. The engine raises `busy` while it shifts. When the last bit is taken in, it pulses `done` for one cycle, and from that point `rx_word` holds the reply right-justified. Chip-select, queueing and multi-word framing belong to the logic around this engine.

Top module: `spx_shift_engine`

## Requirements
- R1: On each transfer, MOSI carries bits `tx_word[n-1]` down to `tx_word[0]` in that order, where n is the effective bit count.
- R2: SCK holds the clock-polarity level of the most recent accepted transfer whenever `busy` is low; it is 0 after reset. Every transfer gives exactly n active-going SCK edges and ends with SCK back at its idle level.
- R3: With phase 0, MOSI is valid for a full half-period before the edge to the active level. MISO is captured at the end of the active half-period, just before SCK returns to idle.
- R4: With phase 1, SCK goes active and MOSI changes on the same cycle. MISO is captured at the end of the following idle half-period.
- R5: While `no_tx` is set for a transfer, MOSI does not change at any point of that transfer and keeps the level it had before.
- R6: While `no_rx` is set for a transfer, MISO is ignored and `rx_word` reads 0 at `done`.
- R7: Each half-period lasts `half_dly`+1 system clock cycles. `done` rises exactly 2·n·(`half_dly`+1) cycles after the clock edge that accepts `start`.
- R8: At `done`, `rx_word[n-1:0]` holds the n MISO bits, with the first bit received at bit n-1, and every higher bit is 0.
- R9: Mode, flags, delay, length and transmit word are captured when `start` is accepted. Changes to these inputs afterwards, and any `start` pulse while `busy` is high, do not affect the transfer under way.
- R10: `done` is high for exactly one cycle, with `busy` low. `rx_word` then stays unchanged until the next accepted `start`.
- R11: A `bit_cnt` of 0, or of more than 32, is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer; taken only when not busy |
| tx_word | input | 32 | Word to send, right-justified |
| bit_cnt | input | 6 | Requested bit count (0 or >32 means 32) |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| no_tx | input | 1 | Suppress MOSI updates |
| no_rx | input | 1 | Ignore MISO, shift in zeros |
| half_dly | input | 8 | Half-period length minus one, in clock cycles |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rx_word | output | 32 | Received word, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |

## Verification
A slave model in the bench changes MISO on the edge opposite to the one the engine should sample. An engine that samples on the wrong edge, or a half-period too early, returns a shifted or corrupted reply. The bench runs lengths of 1, 32 (requested as 0 and as 40) and lengths in between. A wrong clamp or wrong justification shows up as an extra or missing SCK edge, or as stray high bits in `rx_word`. Some transfers change polarity from one transfer to the next, so an engine that idles at the wrong level fails the idle-level check. The suppress flags are checked by holding MOSI and by feeding a busy MISO. A stray `start` and scrambled inputs mid-transfer would alter the reply, the bit count or the cycle count of an engine that does not latch its setup.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = $clog2(WORD_W) + 1;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic no_tx;
    logic no_rx;
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } phase_e;

  // Requested length to effective length: 0 or oversize becomes full width.
  function automatic cnt_t clamp_len(input cnt_t req);
    if (req == '0 || int'(req) > int'(WORD_W)) return cnt_t'(WORD_W);
    return req;
  endfunction

  // Move the n-bit payload so its first bit lands in the top position.
  function automatic word_t justify_left(input word_t w, input cnt_t n);
    int sh;
    sh = int'(WORD_W) - int'(n);
    return w << sh;
  endfunction

  // Ones in the low n positions.
  function automatic word_t low_mask(input cnt_t n);
    if (int'(n) >= int'(WORD_W)) return '1;
    return (word_t'(1) << n) - word_t'(1);
  endfunction
endpackage

// File: rtl/spx_pacer.sv
module spx_pacer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             reload,
  input  logic [DLY_W-1:0] dly_in,
  output logic             expire
);
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W:0]   run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else if (arm) begin
      dly_q <= dly_in;
      cnt_q <= dly_in;
    end else if (reload) begin
      cnt_q <= dly_q;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

  // Independent cycle counter since the last load, for the window check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '1;
    else if (arm || reload)  run_q <= '0;
    else if (run_q != '1)    run_q <= run_q + 1'b1;
  end

  AST_PACE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> run_q == {1'b0, dly_q}); // R7
endmodule

// File: rtl/spx_shifter.sv
module spx_shifter
  import spx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_val,
  input  logic  shift,
  input  logic  rx_bit,
  output word_t sreg,
  output logic  next_msb
);
  word_t sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sreg_q <= '0;
    else if (load)   sreg_q <= load_val;
    else if (shift)  sreg_q <= {sreg_q[WORD_W-2:0], rx_bit};
  end

  assign sreg     = sreg_q;
  assign next_msb = sreg_q[WORD_W-2];

  AST_SREG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sreg_q)); // R10
endmodule

// File: rtl/spx_sequencer.sv
module spx_sequencer
  import spx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  mode_t mode_in,
  input  cnt_t  len_in,
  input  logic  first_msb,
  input  logic  next_msb,
  input  logic  expire,
  output logic  busy,
  output logic  done,
  output logic  sck,
  output logic  mosi,
  output logic  pace_arm,
  output logic  pace_reload,
  output logic  sreg_load,
  output logic  sreg_shift,
  output mode_t mode_q,
  output cnt_t  len_q
);
  phase_e phase_q;
  cnt_t   left_q;
  logic   sck_q, mosi_q, done_q;
  mode_t  mode_r;
  cnt_t   len_r;

  // Named internal events
  logic accept, end_first, end_second, last_bit;
  assign accept     = (phase_q == ST_IDLE) && start;
  assign end_first  = (phase_q == ST_FIRST) && expire;
  assign end_second = (phase_q == ST_SECOND) && expire;
  assign last_bit   = (left_q == cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      left_q  <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_r  <= '0;
      len_r   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_r  <= mode_in;
        len_r   <= len_in;
        left_q  <= len_in;
        phase_q <= ST_FIRST;
        if (!mode_in.no_tx) mosi_q <= first_msb;
        sck_q   <= mode_in.cpha ? ~mode_in.cpol : mode_in.cpol;
      end else if (end_first) begin
        phase_q <= ST_SECOND;
        sck_q   <= mode_r.cpha ? mode_r.cpol : ~mode_r.cpol;
      end else if (end_second) begin
        left_q <= left_q - 1'b1;
        if (last_bit) begin
          phase_q <= ST_IDLE;
          done_q  <= 1'b1;
          sck_q   <= mode_r.cpol;
        end else begin
          phase_q <= ST_FIRST;
          if (!mode_r.no_tx) mosi_q <= next_msb;
          sck_q   <= mode_r.cpha ? ~mode_r.cpol : mode_r.cpol;
        end
      end
    end
  end

  assign busy        = (phase_q != ST_IDLE);
  assign done        = done_q;
  assign sck         = sck_q;
  assign mosi        = mosi_q;
  assign pace_arm    = accept;
  assign pace_reload = end_first || (end_second && !last_bit);
  assign sreg_load   = accept;
  assign sreg_shift  = end_second;
  assign mode_q      = mode_r;
  assign len_q       = len_r;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == mode_r.cpol); // R2
  AST_NOTX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_in.no_tx) |=> $stable(mosi)); // R5
  AST_NOTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_r.no_tx) |=> $stable(mosi)); // R5
  AST_PH0_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_SECOND && !mode_r.cpha && !expire) |=> $stable(mosi)); // R3
  AST_PH1_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_SECOND && mode_r.cpha && !expire) |=> $stable(mosi)); // R4
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0 && int'(left_q) <= int'(WORD_W))); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_r) && $stable(len_r)); // R9
endmodule

// File: rtl/spx_shift_engine.sv
module spx_shift_engine
  import spx_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              no_tx,
  input  logic              no_rx,
  input  logic [DLY_W-1:0]  half_dly,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  cnt_t  len_c;
  word_t just_w;
  mode_t mode_in, mode_q;
  cnt_t  len_q;
  logic  expire, pace_arm, pace_reload, sreg_load, sreg_shift;
  logic  next_msb, rx_bit;
  word_t sreg;
  logic [IDX_W-1:0] first_idx;
  logic  first_src;

  assign len_c   = clamp_len(bit_cnt);
  assign just_w  = justify_left(tx_word, len_c);
  assign mode_in = '{cpol: cpol, cpha: cpha, no_tx: no_tx, no_rx: no_rx};
  assign rx_bit  = mode_q.no_rx ? 1'b0 : miso;

  // Independent path to the first payload bit, used only for checking.
  assign first_idx = IDX_W'(len_c - 1'b1);
  assign first_src = tx_word[first_idx];

  spx_pacer #(.DLY_W(DLY_W)) pacer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (pace_arm),
    .reload (pace_reload),
    .dly_in (half_dly),
    .expire (expire)
  );

  spx_shifter shifter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sreg_load),
    .load_val (just_w),
    .shift    (sreg_shift),
    .rx_bit   (rx_bit),
    .sreg     (sreg),
    .next_msb (next_msb)
  );

  spx_sequencer seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_in     (mode_in),
    .len_in      (len_c),
    .first_msb   (just_w[WORD_W-1]),
    .next_msb    (next_msb),
    .expire      (expire),
    .busy        (busy),
    .done        (done),
    .sck         (sck),
    .mosi        (mosi),
    .pace_arm    (pace_arm),
    .pace_reload (pace_reload),
    .sreg_load   (sreg_load),
    .sreg_shift  (sreg_shift),
    .mode_q      (mode_q),
    .len_q       (len_q)
  );

  assign rx_word = sreg;

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_load && !no_tx) |=> mosi == $past(first_src)); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rx_word & ~low_mask(len_q)) == '0); // R8
  AST_NORX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q.no_rx) |-> rx_word == '0); // R6
endmodule

// File: tb/spx_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spx_shift_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  bit_cnt = '0;
  logic        cpol = 1'b0, cpha = 1'b0, no_tx = 1'b0, no_rx = 1'b0;
  logic [7:0]  half_dly = '0;
  logic        miso = 1'b0;
  logic        busy, done, sck, mosi;
  logic [31:0] rx_word;

  always #2.5 clk = ~clk;

  spx_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .bit_cnt(bit_cnt), .cpol(cpol), .cpha(cpha), .no_tx(no_tx),
    .no_rx(no_rx), .half_dly(half_dly), .miso(miso), .busy(busy),
    .done(done), .rx_word(rx_word), .sck(sck), .mosi(mosi)
  );

  typedef struct {
    logic [31:0] rx_exp;
    logic [31:0] mosi_exp;
    logic [31:0] mask;
    int          len;
    int          cyc_exp;
    logic        pol;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // slave model state, written by the driver before start
  logic [31:0] s_word = '0;
  int          s_len = 1;
  logic        s_cpol = 1'b0, s_cpha = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, got, expv);
    end
  endtask

  function automatic logic slave_bit(input int k);
    if (k < s_len) return s_word[s_len-1-k];
    return 1'b0;
  endfunction

  // Monitor and slave: sample away from the active edge
  logic        prev_sck = 1'b0, prev_busy = 1'b0;
  logic [31:0] cap = '0;
  int          lead = 0, kidx = 0;
  logic        hold_pend = 1'b0;
  logic [31:0] held_rx = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && !busy) begin
        chk("R10 done low after one cycle", {31'b0, done}, 32'h0);
        chk("R10 rx_word held", rx_word, held_rx);
        hold_pend = 1'b0;
      end
      if (busy && !prev_busy) begin
        cap = '0; lead = 0; kidx = 0;
        if (s_cpha) begin
          if (sck != s_cpol) begin
            lead++;
            miso = slave_bit(0);
            kidx = 1;
          end
        end else begin
          miso = slave_bit(0);
        end
      end else if ((busy || done) && sck != prev_sck) begin
        if (sck != s_cpol) begin
          lead++;
          if (!s_cpha) cap = {cap[30:0], mosi};
          else begin
            miso = slave_bit(kidx);
            kidx++;
          end
        end else begin
          if (s_cpha) cap = {cap[30:0], mosi};
          else begin
            kidx++;
            miso = slave_bit(kidx);
          end
        end
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected done", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, "/R8 received word"}, rx_word, e.rx_exp);
          chk({e.tag, "/R1 bits seen on MOSI"}, cap & e.mask, e.mosi_exp);
          chk({e.tag, "/R2 active edge count"}, lead, e.len);
          chk({e.tag, "/R2 SCK idle at done"}, {31'b0, sck}, {31'b0, e.pol});
          chk({e.tag, "/R7 cycles to done"}, cyc, e.cyc_exp);
          chk({e.tag, "/R10 busy low at done"}, {31'b0, busy}, 32'h0);
          held_rx = rx_word;
          hold_pend = 1'b1;
        end
      end
    end
    prev_sck  = sck;
    prev_busy = busy;
  end

  task automatic run_xfer(input logic [31:0] tx, input logic [5:0] lreq,
                          input logic pol, input logic pha,
                          input logic ntx, input logic nrx,
                          input logic [7:0] d, input logic [31:0] sw,
                          input bit poke, input string tag);
    exp_t e;
    int n;
    n = (lreq == 0 || lreq > 32) ? 32 : int'(lreq); // R11
    e.len  = n;
    e.mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    e.rx_exp   = nrx ? 32'h0 : (sw & e.mask);
    e.mosi_exp = ntx ? (mosi ? e.mask : 32'h0) : (tx & e.mask);
    e.cyc_exp  = cyc + 1 + 2 * (int'(d) + 1) * n;
    e.pol = pol;
    e.tag = tag;
    s_word = sw; s_len = n; s_cpol = pol; s_cpha = pha;
    tx_word = tx; bit_cnt = lreq; cpol = pol; cpha = pha;
    no_tx = ntx; no_rx = nrx; half_dly = d;
    start = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    // R9: scramble every setup input once the transfer is accepted
    tx_word = ~tx; bit_cnt = lreq + 6'd3; cpol = ~pol; cpha = ~pha;
    no_tx = ~ntx; no_rx = ~nrx; half_dly = d + 8'd5;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; // R9: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait (done);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset SCK level", {31'b0, sck}, 32'h0);
    chk("R10 reset busy", {31'b0, busy}, 32'h0);
    chk("R10 reset done", {31'b0, done}, 32'h0);
    chk("R8 reset rx_word", rx_word, 32'h0);

    run_xfer(32'h0000_00A5, 6'd8,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0000_003C, 0, "R3 mode0");
    run_xfer(32'h0000_005A, 6'd8,  1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 32'h0000_00C3, 0, "R4 mode1");
    run_xfer(32'hFFFF_1234, 6'd16, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 32'h0000_BEEF, 0, "R3 mode2");
    run_xfer(32'h0000_0ABC, 6'd12, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 32'h0000_0F0D, 0, "R4 mode3");
    run_xfer(32'hDEAD_BEEF, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h8C3A_5E71, 0, "R11 len0");
    run_xfer(32'h1357_9BDF, 6'd40, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 32'hF00F_A55A, 0, "R11 len40");
    run_xfer(32'hFFFF_FFFE, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0, 8'd3, 32'h0000_0001, 0, "R7 len1");
    run_xfer(32'h0000_0001, 6'd1,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0000_0000, 0, "R1 set high");
    run_xfer(32'h0000_0000, 6'd8,  1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 32'h0000_0096, 0, "R5 hold high");
    run_xfer(32'h0000_0000, 6'd1,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0000_0000, 0, "R1 set low");
    run_xfer(32'h0000_00FF, 6'd8,  1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 32'h0000_0069, 0, "R5 hold low");
    run_xfer(32'h0000_0F0F, 6'd12, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 32'h0000_0FFF, 0, "R6 norx");
    run_xfer(32'h0000_02D3, 6'd10, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 32'h0000_0165, 1, "R9 poke");
    run_xfer(32'h0000_0015, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0000_000A, 0, "R2 repol");

    chk("R10 no outstanding transfers", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule